// File: doc/BRIEF.md
# Double to single conversion sequencer

This block narrows a 64-bit double-precision value to the precision and exponent range of single precision. The result stays in 64-bit double format. An operand is taken through a valid/ready handshake together with a 2-bit rounding mode. The block first sorts the operand into one of five classes: zero, NaN/infinity, too large, in range or too small. In-range values are rounded straight to a 24-bit significand. Too-small values are first shifted right one bit per clock cycle until they reach the smallest single exponent. The bits shifted out are kept as guard, round and sticky. The value is then rounded at single-subnormal granularity.

After rounding, the block renormalises the significand one bit per cycle so that the result is a proper double again. It then repacks the value with the double bias. A one-cycle completion pulse marks the result, and the result holds until the next conversion finishes. The block suits an arithmetic pipeline that keeps single-precision results in double-width registers: the unit computes in double and this block narrows the value afterwards.

Top module: `d2s_convert`

## Requirements
- R1: `in_ready` is high only while the block is idle. An operand and mode are taken on a rising edge with `in_valid` and `in_ready` both high. `in_ready` stays low from that edge until the completion pulse has ended, and `in_valid` has no effect during that time.
- R2: `done` is high for exactly one cycle per accepted operand, and `result` changes only on the edge that raises `done`.
- R3: An operand with biased exponent 0 and fraction 0, of either sign, gives an all-zero result.
- R4: An operand with biased exponent 2047 (NaN or infinity) is passed through unchanged.
- R5: An operand with biased exponent from 1151 to 2046 gives an infinity of the same sign: sign bit 63 kept, bits 62..52 all ones, bits 51..0 zero.
- R6: An operand with biased exponent from 897 to 1150 is rounded to a 24-bit significand. Result bits 28..0 are zero, and bits 62..52 hold the unbiased exponent plus 1023.
- R7: Rounding mode encoding: 00 rounds to nearest with ties to even; 01 rounds toward zero; 10 rounds toward plus infinity; 11 rounds toward minus infinity.
- R8: When rounding lifts the unbiased exponent above 127, the result is an infinity of the operand's sign.
- R9: An operand with biased exponent below 897 is treated as having unbiased exponent -1022 with hidden bit 0 if its biased exponent is 0, and biased exponent minus 1023 with hidden bit 1 otherwise. It is then rounded to a multiple of 2^-149 under the selected mode. The denormalisation loop stops after 25 shifts with no change to the rounded result.
- R10: A tiny result that is non-zero is renormalised to a double with a hidden 1, so its biased exponent lies between 874 and 896. A tiny result that rounds to zero keeps the operand's sign in bit 63, and all other bits are zero.
- R11: A carry out of the 24-bit significand during rounding raises the exponent by one. An example is 0x380FFFFFFFFFFFFF rounding to nearest to 0x3810000000000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand and mode are presented |
| in_ready | output | 1 | Block is idle and takes an operand |
| operand | input | 64 | Double-precision operand |
| rnd_mode | input | 2 | Rounding mode (R7 encoding) |
| done | output | 1 | One-cycle pulse: result is new |
| result | output | 64 | Double-format, single-representable result |

## Verification
A fault in the shift loop corrupts the guard, round and sticky bits or the exponent count. This appears at the ports as a tiny result off by one unit of 2^-149, or with a wrong exponent field, on the very conversion that used the loop. A stuck or miscounted state shows up as `in_ready` or `done` out of step with the handshake within one conversion. The watchdog turns such a state into a failure. Class-selection faults appear as a wrong special encoding in the first result for an operand at a class boundary, so directed operands sit on both sides of biased exponents 897 and 1150.

// File: rtl/d2s_pkg.sv
package d2s_pkg;

    // double format
    localparam int unsigned DBL_W     = 64;
    localparam int unsigned DEXP_W    = 11;
    localparam int unsigned DMAN_W    = 52;
    localparam int unsigned SIG_W     = DMAN_W + 1;
    // single significand kept after rounding
    localparam int unsigned SGL_SIG_W = 24;
    localparam int unsigned DROP_W    = SIG_W - SGL_SIG_W;
    // signed working exponent
    localparam int unsigned EXP_W     = DEXP_W + 2;

    localparam int DBIAS      = 1023;
    localparam int SMIN_EXP   = -126;
    localparam int SMAX_EXP   = 127;
    localparam int DSUB_EXP   = 1 - DBIAS;
    localparam int NORM_LO_B  = DBIAS + SMIN_EXP;
    localparam int NORM_HI_B  = DBIAS + SMAX_EXP;

    localparam logic signed [EXP_W-1:0] DBIAS_S  = EXP_W'(DBIAS);
    localparam logic signed [EXP_W-1:0] SMIN_S   = EXP_W'(SMIN_EXP);
    localparam logic signed [EXP_W-1:0] SMAX_S   = EXP_W'(SMAX_EXP);
    localparam logic signed [EXP_W-1:0] DSUB_S   = EXP_W'(DSUB_EXP);

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_ZERO    = 2'b01,
        RM_UP      = 2'b10,
        RM_DOWN    = 2'b11
    } rmode_e;

    typedef enum logic [2:0] {
        K_ZERO, K_SPECIAL, K_OVF, K_NORMAL, K_TINY
    } kind_e;

    typedef enum logic [2:0] {
        S_IDLE, S_SHIFT, S_ROUND, S_NORM, S_DONE
    } state_e;

    typedef struct packed {
        logic                    sign;
        logic signed [EXP_W-1:0] ex;
        logic [SIG_W-1:0]        sig;
    } unp_t;

    typedef struct packed {
        logic g;
        logic r;
        logic x;
    } grx_t;

    function automatic logic round_up(rmode_e m, logic s, logic lsb,
                                      logic g, logic r, logic x);
        logic below;
        below = g | r | x;
        case (m)
            RM_NEAREST: return g & (lsb | r | x);
            RM_UP:      return ~s & below;
            RM_DOWN:    return s & below;
            default:    return 1'b0;
        endcase
    endfunction

    function automatic logic [DBL_W-1:0] signed_inf(logic s);
        return {s, {DEXP_W{1'b1}}, {DMAN_W{1'b0}}};
    endfunction

endpackage

// File: rtl/d2s_unpack.sv
module d2s_unpack
    import d2s_pkg::*;
(
    input  logic [DBL_W-1:0] op,
    output kind_e            kind,
    output unp_t             unp
);
    logic [DEXP_W-1:0] bexp;
    logic [DMAN_W-1:0] mant;

    assign bexp = op[DBL_W-2 -: DEXP_W];
    assign mant = op[DMAN_W-1:0];

    always_comb begin
        unp.sign = op[DBL_W-1];
        if (bexp == '0) begin
            unp.ex  = DSUB_S;
            unp.sig = {1'b0, mant};
        end else begin
            unp.ex  = $signed({2'b00, bexp}) - DBIAS_S;
            unp.sig = {1'b1, mant};
        end
    end

    always_comb begin
        if (bexp == {DEXP_W{1'b1}})
            kind = K_SPECIAL;
        else if (bexp == '0 && mant == '0)
            kind = K_ZERO;
        else if (bexp > DEXP_W'(NORM_HI_B))
            kind = K_OVF;
        else if (bexp < DEXP_W'(NORM_LO_B))
            kind = K_TINY;
        else
            kind = K_NORMAL;
    end
endmodule

// File: rtl/d2s_denorm_step.sv
module d2s_denorm_step
    import d2s_pkg::*;
(
    input  unp_t cur,
    input  grx_t cur_grx,
    output unp_t nxt,
    output grx_t nxt_grx
);
    always_comb begin
        nxt.sign  = cur.sign;
        nxt.ex    = cur.ex + EXP_W'(1);
        nxt.sig   = cur.sig >> 1;
        nxt_grx.x = cur_grx.r | cur_grx.x;
        nxt_grx.r = cur_grx.g;
        nxt_grx.g = cur.sig[0];
    end
endmodule

// File: rtl/d2s_round.sv
module d2s_round
    import d2s_pkg::*;
(
    input  unp_t   cur,
    input  grx_t   cur_grx,
    input  rmode_e mode,
    output unp_t   rnd
);
    logic                 lsb, gb, rb, xb, inc;
    logic [SGL_SIG_W:0]   sum;

    assign lsb = cur.sig[DROP_W];
    assign gb  = cur.sig[DROP_W-1];
    assign rb  = cur.sig[DROP_W-2];
    assign xb  = (|cur.sig[DROP_W-3:0]) | cur_grx.g | cur_grx.r | cur_grx.x;
    assign inc = round_up(mode, cur.sign, lsb, gb, rb, xb);
    assign sum = {1'b0, cur.sig[SIG_W-1:DROP_W]} + (SGL_SIG_W+1)'(inc);

    always_comb begin
        rnd.sign = cur.sign;
        if (sum[SGL_SIG_W]) begin
            rnd.ex  = cur.ex + EXP_W'(1);
            rnd.sig = {1'b1, {(SIG_W-1){1'b0}}};
        end else begin
            rnd.ex  = cur.ex;
            rnd.sig = {sum[SGL_SIG_W-1:0], {DROP_W{1'b0}}};
        end
    end
endmodule

// File: rtl/d2s_convert.sv
module d2s_convert
    import d2s_pkg::*;
#(
    parameter int SHIFT_CAP = 25
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [DBL_W-1:0] operand,
    input  logic [1:0]       rnd_mode,
    output logic             done,
    output logic [DBL_W-1:0] result
);
    localparam int CNT_W = $clog2(SHIFT_CAP + 1);

    state_e           state;
    unp_t             work;
    grx_t             grx;
    rmode_e           mode;
    logic [CNT_W-1:0] cnt;
    logic [DBL_W-1:0] result_q;

    kind_e            in_kind;
    unp_t             in_unp;
    unp_t             step_unp;
    grx_t             step_grx;
    unp_t             rnd_unp;
    logic signed [EXP_W-1:0] biased;

    d2s_unpack u_unpack (
        .op   (operand),
        .kind (in_kind),
        .unp  (in_unp)
    );

    d2s_denorm_step u_step (
        .cur     (work),
        .cur_grx (grx),
        .nxt     (step_unp),
        .nxt_grx (step_grx)
    );

    d2s_round u_round (
        .cur     (work),
        .cur_grx (grx),
        .mode    (mode),
        .rnd     (rnd_unp)
    );

    assign biased = work.ex + DBIAS_S;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            work     <= '0;
            grx      <= '0;
            mode     <= RM_NEAREST;
            cnt      <= '0;
            result_q <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (in_valid) begin
                        work <= in_unp;
                        grx  <= '0;
                        mode <= rmode_e'(rnd_mode);
                        cnt  <= '0;
                        unique case (in_kind)
                            K_ZERO: begin
                                result_q <= '0;
                                state    <= S_DONE;
                            end
                            K_SPECIAL: begin
                                result_q <= operand;
                                state    <= S_DONE;
                            end
                            K_OVF: begin
                                result_q <= signed_inf(in_unp.sign);
                                state    <= S_DONE;
                            end
                            K_TINY:   state <= S_SHIFT;
                            default:  state <= S_ROUND;
                        endcase
                    end
                end
                S_SHIFT: begin
                    if ($signed(work.ex) >= SMIN_S) begin
                        state <= S_ROUND;
                    end else if (cnt == CNT_W'(SHIFT_CAP)) begin
                        work.ex <= SMIN_S;
                        state   <= S_ROUND;
                    end else begin
                        work <= step_unp;
                        grx  <= step_grx;
                        cnt  <= cnt + CNT_W'(1);
                    end
                end
                S_ROUND: begin
                    work  <= rnd_unp;
                    grx   <= '0;
                    state <= S_NORM;
                end
                S_NORM: begin
                    if (work.sig[SIG_W-1:DROP_W] == '0) begin
                        result_q <= {work.sign, {(DBL_W-1){1'b0}}};
                        state    <= S_DONE;
                    end else if (work.sig[SIG_W-1]) begin
                        if ($signed(work.ex) > SMAX_S)
                            result_q <= signed_inf(work.sign);
                        else
                            result_q <= {work.sign, biased[DEXP_W-1:0],
                                         work.sig[DMAN_W-1:0]};
                        state <= S_DONE;
                    end else begin
                        work.sig <= work.sig << 1;
                        work.ex  <= work.ex - EXP_W'(1);
                    end
                end
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign in_ready = (state == S_IDLE);
    assign done     = (state == S_DONE);
    assign result   = result_q;
endmodule

// File: rtl/d2s_convert_chk.sv
module d2s_convert_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic        done,
    input logic [63:0] result
);
    assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    assert_ready_done_excl_R1: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && done));

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_result_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

    assert_low_bits_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (done && result[62:52] != 11'h7FF) |-> (result[28:0] == 29'd0));

    assert_exp_window_R10: assert property (@(posedge clk) disable iff (rst)
        (done && result[62:52] != 11'h7FF && result[62:0] != 63'd0)
        |-> (result[62:52] >= 11'd874 && result[62:52] <= 11'd1150));
endmodule

bind d2s_convert d2s_convert_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .done     (done),
    .result   (result)
);

// File: tb/d2s_convert_bench.sv
module d2s_convert_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] operand = '0;
    logic [1:0]  rnd_mode = 2'b00;
    logic        done;
    logic [63:0] result;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #5 clk = ~clk;

    d2s_convert u_d2s_convert (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .operand  (operand),
        .rnd_mode (rnd_mode),
        .done     (done),
        .result   (result)
    );

    // reference built from the requirement text with wide integer shifts
    function automatic logic [63:0] ref_d2s(input logic [63:0] op, input logic [1:0] rm);
        logic        s;
        int          be, e, sh, ee;
        logic [63:0] m, q, rem, half;
        logic        up;
        s  = op[63];
        be = int'(op[62:52]);
        if (be == 2047) return op;
        if (be == 0 && op[51:0] == 52'd0) return 64'd0;
        if (be > 1150) return {s, 11'h7FF, 52'd0};
        m = {11'd0, (be != 0), op[51:0]};
        e = (be == 0) ? -1022 : be - 1023;
        if (e >= -126) begin sh = 29; ee = e; end
        else begin sh = 29 + (-126 - e); ee = -126; end
        if (sh > 60) begin
            q = 64'd0; rem = m; half = 64'd1 << 60;
        end else begin
            q = m >> sh;
            rem = m & ((64'd1 << sh) - 64'd1);
            half = 64'd1 << (sh - 1);
        end
        case (rm)
            2'b00:   up = (rem > half) || (rem == half && q[0]);
            2'b10:   up = !s && rem != 64'd0;
            2'b11:   up = s && rem != 64'd0;
            default: up = 1'b0;
        endcase
        q = q + 64'(up);
        if (q == (64'd1 << 24)) begin q = 64'd1 << 23; ee = ee + 1; end
        if (q == 64'd0) return {s, 63'd0};
        while (q < (64'd1 << 23)) begin q = q << 1; ee = ee - 1; end
        if (ee > 127) return {s, 11'h7FF, 52'd0};
        return {s, 11'(ee + 1023), q[22:0], 29'd0};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic convert(input logic [63:0] op, input logic [1:0] rm,
                           output logic [63:0] res);
        int n;
        @(negedge clk);
        chk("R1", "in_ready idle", 64'(in_ready), 64'd1);
        in_valid = 1'b1; operand = op; rnd_mode = rm;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1", "in_ready busy", 64'(in_ready), 64'd0);
        n = 0;
        while (!done && n < 300) begin @(negedge clk); n++; end
        if (!done) chk("R2", "done timeout", 64'd0, 64'd1);
        res = result;
    endtask

    task automatic run(input string req, input logic [63:0] op,
                       input logic [1:0] rm, input logic [63:0] expv);
        logic [63:0] res;
        convert(op, rm, res);
        chk(req, $sformatf("op=%h rm=%0d", op, rm), res, expv);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            fails++;
            $display("FAIL watchdog actual=expired expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] res, held;
        int n;
        void'($urandom(32'd20210608));
        repeat (3) @(negedge clk);
        // reset state
        chk("R1", "reset in_ready", 64'(in_ready), 64'd1);
        chk("R2", "reset done", 64'(done), 64'd0);
        chk("R2", "reset result", result, 64'd0);
        rst = 1'b0;

        // R3 zero
        run("R3", 64'h0000000000000000, 2'b00, 64'd0);
        run("R3", 64'h8000000000000000, 2'b11, 64'd0);
        // R4 pass-through
        run("R4", 64'h7FF8000000000001, 2'b00, 64'h7FF8000000000001);
        run("R4", 64'hFFF0000000000000, 2'b01, 64'hFFF0000000000000);
        // R5 too large
        run("R5", 64'h4800000000000000, 2'b00, 64'h7FF0000000000000);
        run("R5", 64'hC7F0000000000000, 2'b01, 64'hFFF0000000000000);
        // R6 in range
        run("R6", 64'h3FF0000000000000, 2'b00, 64'h3FF0000000000000);
        run("R6", 64'h3FF0000010000000, 2'b00, 64'h3FF0000000000000);
        // R7 modes
        run("R7", 64'h3FF0000030000000, 2'b00, 64'h3FF0000040000000);
        run("R7", 64'h3FF00000FFFFFFFF, 2'b01, 64'h3FF00000E0000000);
        run("R7", 64'h3FF0000000000001, 2'b10, 64'h3FF0000020000000);
        run("R7", 64'h3FF0000000000001, 2'b11, 64'h3FF0000000000000);
        run("R7", 64'hBFF0000000000001, 2'b11, 64'hBFF0000020000000);
        // R8 overflow after rounding, and its non-overflow neighbour
        run("R8", 64'h47EFFFFFFFFFFFFF, 2'b00, 64'h7FF0000000000000);
        run("R8", 64'h47EFFFFFFFFFFFFF, 2'b01, 64'h47EFFFFFE0000000);
        // R11 carry
        run("R11", 64'h3FFFFFFFFFFFFFFF, 2'b00, 64'h4000000000000000);
        run("R11", 64'h380FFFFFFFFFFFFF, 2'b00, 64'h3810000000000000);
        // R9 tiny
        run("R9", 64'h36A0000000000000, 2'b00, 64'h36A0000000000000);
        run("R9", 64'h3690000000000000, 2'b10, 64'h36A0000000000000);
        run("R9", 64'h0010000000000000, 2'b11, 64'h0000000000000000);
        run("R9", 64'h3810000000000000, 2'b00, 64'h3810000000000000);
        // R10 renormalise and signed zero
        run("R10", 64'h3690000000000000, 2'b00, 64'h0000000000000000);
        run("R10", 64'hB690000000000000, 2'b00, 64'h8000000000000000);
        run("R10", 64'h0000000000000001, 2'b10, 64'h36A0000000000000);
        run("R10", 64'h8000000000000001, 2'b11, 64'hB6A0000000000000);

        // R1: valid held with another operand while busy is ignored
        @(negedge clk);
        in_valid = 1'b1; operand = 64'h3800000000000003; rnd_mode = 2'b10;
        @(negedge clk);
        operand = 64'h3FF0000000000000; rnd_mode = 2'b00;
        n = 0;
        while (!done && n < 300) begin
            chk("R1", "in_ready while busy", 64'(in_ready), 64'd0);
            @(negedge clk); n++;
        end
        in_valid = 1'b0;
        chk("R1", "busy input ignored", result, ref_d2s(64'h3800000000000003, 2'b10));
        held = result;
        @(negedge clk);
        chk("R2", "done one cycle", 64'(done), 64'd0);
        repeat (5) begin
            @(negedge clk);
            chk("R2", "no extra done", 64'(done), 64'd0);
        end
        chk("R2", "result held", result, held);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [63:0] op;
            logic [1:0]  rm;
            int          be, pick;
            op   = {$urandom, $urandom};
            rm   = 2'($urandom_range(0, 3));
            pick = $urandom_range(0, 19);
            if (pick == 0) be = 0;
            else if (pick == 1) be = 2047;
            else be = $urandom_range(860, 1160);
            op[62:52] = 11'(be);
            run((be < 897) ? "R9" : (be > 1150) ? "R5" : "R6", op, rm, ref_d2s(op, rm));
        end

        ended = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule